// File: doc/BRIEF.md
# One-Hot FIFO Pointer Proximity Monitor

This block watches the write and read pointers of a small elastic FIFO in which each pointer is a one-hot token that rotates by one position per access. It owns both pointer registers, advances them on write and read strobes, and hands them out to address the storage. It compares the two tokens every cycle and reports when they come within two positions of each other, within one position, or land on the same position. The distance is measured around the ring in both directions.

Because the write pointer is a shift register, losing its token leaves it at all zeros. Once that happens, further write strobes cannot bring the token back. The block flags this stuck state, and while it lasts it reports no pointer-proximity alarms, because they would mean nothing. A sync input reloads both tokens to a fixed starting offset half the ring apart, and this is the only way out of the stuck state. An error-injection input clears the write token, so the stuck path can be exercised.

All alarms are single-cycle events meant to set bits in a downstream sticky status register. An event fires once when its condition begins and does not fire again until the condition has ended and returned.

Top module: `fifo_ptr_monitor`

## Requirements
- R1: While and after synchronous reset, the write pointer is bit 0 only, the read pointer is bit DEPTH/2 only, and all four alarm outputs are low.
- R2: When sync is high at a clock edge, that edge loads the write pointer with bit 0 only and the read pointer with bit DEPTH/2 only. Sync takes priority over wr_adv, rd_adv and wr_token_drop in the same cycle.
- R3: When wr_adv is high (and neither sync nor wr_token_drop is high), the write token moves from bit i to bit i+1, and from bit DEPTH-1 it wraps to bit 0. The read token moves the same way on rd_adv. With no strobe, a pointer holds.
- R4: alarm_collide pulses when both pointers hold their token on the same bit. It rises one clock after the edge at which the pointers became equal.
- R5: alarm_near1 pulses when the circular distance between the tokens, taken the shorter way round the ring, becomes 1 or less. It has the same one-clock latency as R4.
- R6: alarm_near2 pulses when that circular distance becomes 2 or less. It has the same latency.
- R7: Each alarm is high for exactly one cycle when its condition starts. It does not fire again while the condition persists, and it fires again after the condition has cleared and returned.
- R8: wr_token_drop (without sync) clears the write pointer to all zeros, taking priority over wr_adv. alarm_stuck pulses one clock after the write pointer becomes all zeros.
- R9: An all-zero write pointer stays all zeros under any wr_adv activity until a sync.
- R10: While the write pointer is all zeros, alarm_collide, alarm_near1 and alarm_near2 stay low, wherever the read pointer is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Reload both pointers to their start offsets |
| wr_adv | input | 1 | Advance the write token by one position |
| rd_adv | input | 1 | Advance the read token by one position |
| wr_token_drop | input | 1 | Error injection: clear the write token |
| wr_ptr | output | DEPTH | One-hot write pointer |
| rd_ptr | output | DEPTH | One-hot read pointer |
| alarm_stuck | output | 1 | Event: the write pointer has become all zeros |
| alarm_near2 | output | 1 | Event: the tokens are within two positions |
| alarm_near1 | output | 1 | Event: the tokens are within one position |
| alarm_collide | output | 1 | Event: the tokens are on the same position |

## Verification
The main overlap is a sync arriving in the same cycle as a token drop and a write advance. The bench provokes it after the write pointer is already stuck, expects the start offsets on both pointers, and expects no stuck event afterwards. A second overlap is the token loss happening while the read token sits next to the write token. The bench drives the read token into the collision position while the write pointer is empty and requires a stuck event with no proximity events. A reference model built on integer positions predicts every alarm and pointer value on each cycle, through both directed approaches from either side of the ring and a long random stretch.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Widest proximity window checked (positions apart)
    localparam int unsigned FPM_NEAR_SPAN = 2;

    typedef struct packed {
        logic stuck;
        logic near2;
        logic near1;
        logic collide;
    } fpm_alarm_t;

    typedef enum logic [1:0] {
        PTR_HOLD,
        PTR_STEP,
        PTR_LOAD,
        PTR_DROP
    } fpm_ptr_op_e;

    // Pointer operation, priority load > drop > step > hold
    function automatic fpm_ptr_op_e fpm_ptr_op(input logic load,
                                               input logic drop,
                                               input logic step);
        if (load)      return PTR_LOAD;
        else if (drop) return PTR_DROP;
        else if (step) return PTR_STEP;
        else           return PTR_HOLD;
    endfunction

    // match[k]: tokens exactly k positions apart in either direction
    function automatic fpm_alarm_t fpm_classify(input logic stuck,
                                                input logic [FPM_NEAR_SPAN:0] match);
        fpm_alarm_t a;
        a.stuck   = stuck;
        a.collide = !stuck && match[0];
        a.near1   = !stuck && (match[0] || match[1]);
        a.near2   = !stuck && (|match);
        return a;
    endfunction

endpackage

// File: rtl/fpm_ring_ptr.sv
module fpm_ring_ptr
    import fpm_pkg::*;
#(
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned LOAD_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  fpm_ptr_op_e       op,
    output logic [DEPTH-1:0]  ptr
);

    localparam logic [DEPTH-1:0] LOAD_VEC = {{(DEPTH-1){1'b0}}, 1'b1} << LOAD_IDX;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= LOAD_VEC;
        end else begin
            unique case (op)
                PTR_LOAD: ptr <= LOAD_VEC;
                PTR_DROP: ptr <= '0;
                PTR_STEP: ptr <= {ptr[DEPTH-2:0], ptr[DEPTH-1]};
                default:  ptr <= ptr;
            endcase
        end
    end

endmodule

// File: rtl/fpm_proximity.sv
module fpm_proximity
    import fpm_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic [DEPTH-1:0] wr_ptr,
    input  logic [DEPTH-1:0] rd_ptr,
    output fpm_alarm_t       cond
);

    logic [FPM_NEAR_SPAN:0] match;

    // Compare the write token against the read token rotated k places each way
    for (genvar k = 0; k <= FPM_NEAR_SPAN; k++) begin : g_span
        localparam int unsigned BACK = DEPTH - k;
        logic [DEPTH-1:0] rd_up;
        logic [DEPTH-1:0] rd_dn;
        assign rd_up = (rd_ptr << k) | (rd_ptr >> BACK);
        assign rd_dn = (rd_ptr >> k) | (rd_ptr << BACK);
        assign match[k] = (wr_ptr == rd_up) || (wr_ptr == rd_dn);
    end

    always_comb begin
        cond = fpm_classify(~|wr_ptr, match);
    end

endmodule

// File: rtl/fpm_event_gen.sv
module fpm_event_gen
    import fpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fpm_alarm_t cond,
    output fpm_alarm_t evt
);

    fpm_alarm_t cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            evt    <= '0;
        end else begin
            cond_q <= cond;
            evt    <= cond & ~cond_q;
        end
    end

endmodule

// File: rtl/fifo_ptr_monitor.sv
// DEPTH must be even and at least 6 so the two-apart window is distinct.
module fifo_ptr_monitor
    import fpm_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync,
    input  logic             wr_adv,
    input  logic             rd_adv,
    input  logic             wr_token_drop,
    output logic [DEPTH-1:0] wr_ptr,
    output logic [DEPTH-1:0] rd_ptr,
    output logic             alarm_stuck,
    output logic             alarm_near2,
    output logic             alarm_near1,
    output logic             alarm_collide
);

    localparam int unsigned RD_START = DEPTH / 2;

    fpm_ptr_op_e wr_op;
    fpm_ptr_op_e rd_op;
    fpm_alarm_t  cond;
    fpm_alarm_t  evt;

    assign wr_op = fpm_ptr_op(sync, wr_token_drop, wr_adv);
    assign rd_op = fpm_ptr_op(sync, 1'b0, rd_adv);

    fpm_ring_ptr #(.DEPTH(DEPTH), .LOAD_IDX(0)) u_wr_ptr (
        .clk (clk),
        .rst (rst),
        .op  (wr_op),
        .ptr (wr_ptr)
    );

    fpm_ring_ptr #(.DEPTH(DEPTH), .LOAD_IDX(RD_START)) u_rd_ptr (
        .clk (clk),
        .rst (rst),
        .op  (rd_op),
        .ptr (rd_ptr)
    );

    fpm_proximity #(.DEPTH(DEPTH)) u_prox (
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .cond   (cond)
    );

    fpm_event_gen u_evt (
        .clk  (clk),
        .rst  (rst),
        .cond (cond),
        .evt  (evt)
    );

    assign alarm_stuck   = evt.stuck;
    assign alarm_near2   = evt.near2;
    assign alarm_near1   = evt.near1;
    assign alarm_collide = evt.collide;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
    parameter int unsigned DEPTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sync,
    input logic             wr_adv,
    input logic             wr_token_drop,
    input logic [DEPTH-1:0] wr_ptr,
    input logic [DEPTH-1:0] rd_ptr,
    input logic             alarm_stuck,
    input logic             alarm_near2,
    input logic             alarm_near1,
    input logic             alarm_collide
);

    localparam logic [DEPTH-1:0] WR_START = {{(DEPTH-1){1'b0}}, 1'b1};
    localparam logic [DEPTH-1:0] RD_START = WR_START << (DEPTH / 2);

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (rst)
        sync |=> (wr_ptr == WR_START) && (rd_ptr == RD_START)); // R2

    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_ptr) == 1); // R3

    AST_WR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!sync && !wr_token_drop && wr_adv) |=>
            (wr_ptr == {$past(wr_ptr[DEPTH-2:0]), $past(wr_ptr[DEPTH-1])})); // R3

    AST_COLLIDE_EQUAL: assert property (@(posedge clk) disable iff (rst)
        alarm_collide |-> $past(wr_ptr == rd_ptr)); // R4

    AST_COLLIDE_PULSE: assert property (@(posedge clk) disable iff (rst)
        alarm_collide |=> !alarm_collide); // R7

    AST_NEAR1_PULSE: assert property (@(posedge clk) disable iff (rst)
        alarm_near1 |=> !alarm_near1); // R7

    AST_WR_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_ptr)); // R8

    AST_STUCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        alarm_stuck |-> ($past(wr_ptr) == '0)); // R8

    AST_STUCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sync && wr_ptr == '0) |=> (wr_ptr == '0)); // R9

    AST_NO_PROX_STUCK: assert property (@(posedge clk) disable iff (rst)
        (alarm_near2 || alarm_near1 || alarm_collide) |-> ($past(wr_ptr) != '0)); // R10

endmodule

bind fifo_ptr_monitor fpm_checker #(.DEPTH(DEPTH)) u_fpm_checker (
    .clk           (clk),
    .rst           (rst),
    .sync          (sync),
    .wr_adv        (wr_adv),
    .wr_token_drop (wr_token_drop),
    .wr_ptr        (wr_ptr),
    .rd_ptr        (rd_ptr),
    .alarm_stuck   (alarm_stuck),
    .alarm_near2   (alarm_near2),
    .alarm_near1   (alarm_near1),
    .alarm_collide (alarm_collide)
);

// File: tb/test_fifo_ptr_monitor.sv
`timescale 1ns/1ps
module test_fifo_ptr_monitor;

    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sync = 1'b0;
    logic         wr_adv = 1'b0;
    logic         rd_adv = 1'b0;
    logic         wr_token_drop = 1'b0;
    logic [D-1:0] wr_ptr;
    logic [D-1:0] rd_ptr;
    logic         alarm_stuck;
    logic         alarm_near2;
    logic         alarm_near1;
    logic         alarm_collide;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fifo_ptr_monitor #(.DEPTH(D)) i_fifo_ptr_monitor (
        .clk           (clk),
        .rst           (rst),
        .sync          (sync),
        .wr_adv        (wr_adv),
        .rd_adv        (rd_adv),
        .wr_token_drop (wr_token_drop),
        .wr_ptr        (wr_ptr),
        .rd_ptr        (rd_ptr),
        .alarm_stuck   (alarm_stuck),
        .alarm_near2   (alarm_near2),
        .alarm_near1   (alarm_near1),
        .alarm_collide (alarm_collide)
    );

    // ---------------- reference model on integer positions ----------------
    int       m_wpos  = 0;
    int       m_rpos  = D / 2;
    bit       m_wlive = 1'b1;
    bit [3:0] m_prev  = '0;   // {stuck, near2, near1, collide}
    bit [3:0] m_alarm = '0;

    function automatic bit [3:0] model_cond(int w, int r, bit live);
        int d;
        if (!live) return 4'b1000;
        d = (w - r + D) % D;
        if (D - d < d) d = D - d;
        return {1'b0, d <= 2, d <= 1, d == 0};
    endfunction

    function automatic logic [D-1:0] token(int pos, bit live);
        logic [D-1:0] v = '0;
        if (live) v[pos] = 1'b1;
        return v;
    endfunction

    always @(posedge clk) begin
        bit [3:0] c;
        if (rst) begin
            m_wpos = 0; m_rpos = D / 2; m_wlive = 1'b1;
            m_prev = '0; m_alarm = '0;
        end else begin
            c       = model_cond(m_wpos, m_rpos, m_wlive);
            m_alarm = c & ~m_prev;
            m_prev  = c;
            if (sync) begin
                m_wpos = 0; m_rpos = D / 2; m_wlive = 1'b1;
            end else begin
                if (wr_token_drop)            m_wlive = 1'b0;
                else if (wr_adv && m_wlive)   m_wpos = (m_wpos + 1) % D;
                if (rd_adv)                   m_rpos = (m_rpos + 1) % D;
            end
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(wr_ptr == token(m_wpos, m_wlive), "R3/R8", "wr_ptr", 32'(wr_ptr), 32'(token(m_wpos, m_wlive)));
            check(rd_ptr == token(m_rpos, 1'b1), "R3", "rd_ptr", 32'(rd_ptr), 32'(token(m_rpos, 1'b1)));
            check(alarm_collide == m_alarm[0], "R4/R7", "alarm_collide", 32'(alarm_collide), 32'(m_alarm[0]));
            check(alarm_near1 == m_alarm[1], "R5/R7", "alarm_near1", 32'(alarm_near1), 32'(m_alarm[1]));
            check(alarm_near2 == m_alarm[2], "R6/R7", "alarm_near2", 32'(alarm_near2), 32'(m_alarm[2]));
            check(alarm_stuck == m_alarm[3], "R8/R10", "alarm_stuck", 32'(alarm_stuck), 32'(m_alarm[3]));
        end
    end

    task automatic drive(bit s, bit wa, bit ra, bit dr);
        @(negedge clk);
        sync = s; wr_adv = wa; rd_adv = ra; wr_token_drop = dr;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        #2000000;
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int prox_seen;
        int evt_cnt;
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check(wr_ptr == 8'h01, "R1", "wr_ptr in reset", 32'(wr_ptr), 32'h01);
        check(rd_ptr == 8'h10, "R1", "rd_ptr in reset", 32'(rd_ptr), 32'h10);
        check({alarm_stuck, alarm_near2, alarm_near1, alarm_collide} == 4'b0, "R1", "alarms in reset",
              32'({alarm_stuck, alarm_near2, alarm_near1, alarm_collide}), 32'h0);
        rst = 1'b0;

        // R3 R5 R6 R4 R7: write token walks around, approaching read from below then leaving
        for (int i = 0; i < 2 * D; i++) drive(0, 1, 0, 0);
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);

        // R3: both advance together, distance constant, no events
        evt_cnt = 0;
        for (int i = 0; i < D; i++) begin
            drive(0, 1, 1, 0);
            evt_cnt += alarm_near2 + alarm_near1 + alarm_collide;
        end
        check(evt_cnt == 0, "R7", "events while distance fixed", 32'(evt_cnt), 32'h0);

        // R5 R6 R4: read token approaches write token from the other side
        for (int i = 0; i < D; i++) drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);

        // R7: hold at collision, event must not repeat
        drive(1, 0, 0, 0);
        for (int i = 0; i < D / 2; i++) drive(0, 1, 0, 0);
        evt_cnt = 0;
        for (int i = 0; i < 6; i++) begin
            drive(0, 0, 0, 0);
            evt_cnt += alarm_collide;
        end
        check(evt_cnt == 1, "R7", "collide pulses while held", 32'(evt_cnt), 32'h1);

        // R8 R10: read token next to write token, drop the write token
        drive(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) drive(0, 0, 1, 0);   // rd at 7, wr at 0
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        drive(0, 1, 0, 1);                              // drop beats advance
        prox_seen = 0;
        evt_cnt = 0;
        for (int i = 0; i < 5; i++) begin
            drive(0, 1, (i < 1), 0);                    // rd moves onto bit 0
            prox_seen += alarm_near2 + alarm_near1 + alarm_collide;
            evt_cnt   += alarm_stuck;
        end
        check(evt_cnt == 1, "R8", "stuck event count", 32'(evt_cnt), 32'h1);
        check(prox_seen == 0, "R10", "proximity events while stuck", 32'(prox_seen), 32'h0);
        check(wr_ptr == '0, "R9", "wr_ptr after advances while stuck", 32'(wr_ptr), 32'h0);

        // R2: sync together with drop and advances
        drive(1, 1, 1, 1);
        drive(0, 0, 0, 0);
        check(wr_ptr == 8'h01, "R2", "wr_ptr after sync", 32'(wr_ptr), 32'h01);
        check(rd_ptr == 8'h10, "R2", "rd_ptr after sync", 32'(rd_ptr), 32'h10);
        drive(0, 0, 0, 0);
        check(alarm_stuck == 1'b0, "R2", "no stuck event after sync", 32'(alarm_stuck), 32'h0);

        // Random stretch
        for (int i = 0; i < 4000; i++)
            drive(($urandom % 32) == 0, $urandom % 2, $urandom % 2, ($urandom % 24) == 0);
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        finish_run();
    end

endmodule